// File: doc/BRIEF.md
# Dual-Access True-LRU Set Tracker

This block holds the full recency order of one set of a set-associative second-level cache. Each way carries a rank, where 0 is most recently used and WAYS-1 is least recently used. Up to three touches can arrive in one cycle: a hit from the instruction-fetch path, a hit from the memory-stage path, and a fill that installs a new block. All touches that arrive together are applied in a fixed order within that cycle. The memory-stage hit goes first, then the fetch hit, then the fill.

The block also keeps one occupancy bit per way. It offers a replacement victim, which is the lowest-numbered empty way if one exists and otherwise the least recently used way. Surrounding logic does the tag compare, the data storage and the set selection. One copy of this tracker serves each set.

Top module: `lru_set_tracker`

## Requirements
- R1: After a synchronous reset, all ways are empty (`way_valid_o` = 0), way i has rank i, `victim_way_o` = 0 and `victim_free_o` = 1.
- R2: The rank fields, with way i at bits [i*RANK_W +: RANK_W] of `rank_o`, always hold each value 0..WAYS-1 exactly once.
- R3: A single touch of way w sets rank(w) to 0. Every way whose rank was below the old rank(w) goes up by one. All other ranks stay the same. The new ranks appear at `rank_o` after the next rising edge.
- R4: A fill to way w sets `way_valid_o[w]` and moves w to rank 0. The fill is applied after any hits in the same cycle, so the filled way ends at rank 0.
- R5: If the fetch hit and the memory-stage hit land on different ways in the same cycle and there is no fill, the fetch way ends at rank 0 and the memory-stage way ends at rank 1.
- R6: If both hits in one cycle name the same way, the result is the same as one touch of that way.
- R7: In a cycle with no touch, all ranks stay the same. A hit never changes the occupancy bits. Occupancy bits are cleared only by reset, so replacing a block does not by itself disturb the order.
- R8: `victim_way_o` and `victim_free_o` describe the state shown at `rank_o` and `way_valid_o` in the same cycle. If any way is empty, the victim is the lowest-numbered empty way and `victim_free_o` = 1. Otherwise the victim is the way with rank WAYS-1 and `victim_free_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_hit_vld_i | input | 1 | Hit from the fetch path this cycle |
| fe_hit_way_i | input | WAY_W | Way hit by the fetch path |
| ms_hit_vld_i | input | 1 | Hit from the memory stage this cycle |
| ms_hit_way_i | input | WAY_W | Way hit by the memory stage |
| fill_vld_i | input | 1 | New block installed this cycle |
| fill_way_i | input | WAY_W | Way receiving the new block |
| rank_o | output | WAYS*RANK_W | Registered rank of every way |
| way_valid_o | output | WAYS | Registered occupancy bits |
| victim_way_o | output | WAY_W | Registered replacement choice |
| victim_free_o | output | 1 | Victim is an empty way |

## Verification
The bench runs a 4-way tracker through every combination of memory-stage hit, fetch hit and fill, with each source either absent or naming any way. It does this twice, in opposite sweep orders, so the patterns start from many different recency states and from both empty and full sets.

Several faults show up in this sweep:
- Swapping the order of the two hit sources would leave the memory-stage way at MRU instead of MRU-1.
- Promoting a shared way twice, or incrementing ranks that sit above the touched one, would break the permutation.
- Applying a fill before the hits would leave the filled block below MRU.
- A victim picker that prefers the highest empty way, or that reads a stale state, would name the wrong way.

// File: rtl/lru_trk_pkg.sv
package lru_trk_pkg;
  // Order in which same-cycle touches are applied (first to last).
  typedef enum logic [1:0] {
    SRC_MEM   = 2'd0,
    SRC_FETCH = 2'd1,
    SRC_FILL  = 2'd2
  } touch_src_e;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/lru_touch_stage.sv
module lru_touch_stage #(
  parameter int WAYS   = 16,
  parameter int WAY_W  = $clog2(WAYS),
  parameter int RANK_W = WAY_W
) (
  input  logic [WAYS*RANK_W-1:0] rank_in,
  input  logic                   touch_vld,
  input  logic [WAY_W-1:0]       touch_way,
  output logic [WAYS*RANK_W-1:0] rank_out
);
  logic [RANK_W-1:0] old_rank;

  always_comb begin
    old_rank = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == touch_way) old_rank = rank_in[i*RANK_W +: RANK_W];
    end
  end

  always_comb begin
    rank_out = rank_in;
    if (touch_vld) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WAY_W'(i) == touch_way)
          rank_out[i*RANK_W +: RANK_W] = '0;
        else if (rank_in[i*RANK_W +: RANK_W] < old_rank)
          rank_out[i*RANK_W +: RANK_W] = rank_in[i*RANK_W +: RANK_W] + RANK_W'(1);
      end
    end
  end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int WAYS   = 16,
  parameter int WAY_W  = $clog2(WAYS),
  parameter int RANK_W = WAY_W
) (
  input  logic [WAYS*RANK_W-1:0] rank_in,
  input  logic [WAYS-1:0]        valid_in,
  output logic [WAY_W-1:0]       victim_way,
  output logic                   victim_free
);
  localparam logic [RANK_W-1:0] LRU_RANK = RANK_W'(WAYS - 1);

  logic [WAY_W-1:0] free_way;
  logic             any_free;
  logic [WAY_W-1:0] lru_way;

  always_comb begin
    free_way = '0;
    any_free = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid_in[i] && !any_free) begin
        free_way = WAY_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (rank_in[i*RANK_W +: RANK_W] == LRU_RANK) lru_way = WAY_W'(i);
    end
  end

  assign victim_way  = any_free ? free_way : lru_way;
  assign victim_free = any_free;
endmodule

// File: rtl/lru_set_tracker.sv
module lru_set_tracker #(
  parameter int WAYS   = 16,
  parameter int WAY_W  = $clog2(WAYS),
  parameter int RANK_W = WAY_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fe_hit_vld_i,
  input  logic [WAY_W-1:0]       fe_hit_way_i,
  input  logic                   ms_hit_vld_i,
  input  logic [WAY_W-1:0]       ms_hit_way_i,
  input  logic                   fill_vld_i,
  input  logic [WAY_W-1:0]       fill_way_i,
  output logic [WAYS*RANK_W-1:0] rank_o,
  output logic [WAYS-1:0]        way_valid_o,
  output logic [WAY_W-1:0]       victim_way_o,
  output logic                   victim_free_o
);
  import lru_trk_pkg::*;

  logic [WAYS*RANK_W-1:0] rank_q;
  logic [WAYS-1:0]        valid_q;
  logic [WAY_W-1:0]       victim_q;
  logic                   free_q;

  logic                   src_vld [NUM_SRC];
  logic [WAY_W-1:0]       src_way [NUM_SRC];
  logic [WAYS*RANK_W-1:0] chain   [NUM_SRC+1];

  logic [WAYS-1:0]        valid_nxt;
  logic [WAY_W-1:0]       victim_nxt;
  logic                   free_nxt;

  // Sources are listed in application order: memory stage, fetch, fill.
  always_comb begin
    src_vld[SRC_MEM]   = ms_hit_vld_i;
    src_way[SRC_MEM]   = ms_hit_way_i;
    src_vld[SRC_FETCH] = fe_hit_vld_i;
    src_way[SRC_FETCH] = fe_hit_way_i;
    src_vld[SRC_FILL]  = fill_vld_i;
    src_way[SRC_FILL]  = fill_way_i;
  end

  assign chain[0] = rank_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_stage
    lru_touch_stage #(
      .WAYS   (WAYS),
      .WAY_W  (WAY_W),
      .RANK_W (RANK_W)
    ) stage_i (
      .rank_in   (chain[s]),
      .touch_vld (src_vld[s]),
      .touch_way (src_way[s]),
      .rank_out  (chain[s+1])
    );
  end

  always_comb begin
    valid_nxt = valid_q;
    for (int i = 0; i < WAYS; i++) begin
      if (fill_vld_i && fill_way_i == WAY_W'(i)) valid_nxt[i] = 1'b1;
    end
  end

  lru_victim_pick #(
    .WAYS   (WAYS),
    .WAY_W  (WAY_W),
    .RANK_W (RANK_W)
  ) pick_i (
    .rank_in     (chain[NUM_SRC]),
    .valid_in    (valid_nxt),
    .victim_way  (victim_nxt),
    .victim_free (free_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) rank_q[i*RANK_W +: RANK_W] <= RANK_W'(i);
      valid_q  <= '0;
      victim_q <= '0;
      free_q   <= 1'b1;
    end else begin
      rank_q   <= chain[NUM_SRC];
      valid_q  <= valid_nxt;
      victim_q <= victim_nxt;
      free_q   <= free_nxt;
    end
  end

  assign rank_o        = rank_q;
  assign way_valid_o   = valid_q;
  assign victim_way_o  = victim_q;
  assign victim_free_o = free_q;
endmodule

// File: rtl/lru_set_tracker_chk.sv
module lru_set_tracker_chk #(
  parameter int WAYS   = 16,
  parameter int WAY_W  = $clog2(WAYS),
  parameter int RANK_W = WAY_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   fe_hit_vld_i,
  input logic [WAY_W-1:0]       fe_hit_way_i,
  input logic                   ms_hit_vld_i,
  input logic [WAY_W-1:0]       ms_hit_way_i,
  input logic                   fill_vld_i,
  input logic [WAY_W-1:0]       fill_way_i,
  input logic [WAYS*RANK_W-1:0] rank_o,
  input logic [WAYS-1:0]        way_valid_o,
  input logic [WAY_W-1:0]       victim_way_o,
  input logic                   victim_free_o
);
  function automatic logic [RANK_W-1:0] rank_of(logic [WAYS*RANK_W-1:0] r, logic [WAY_W-1:0] w);
    logic [RANK_W-1:0] v;
    v = '0;
    for (int i = 0; i < WAYS; i++) if (WAY_W'(i) == w) v = r[i*RANK_W +: RANK_W];
    return v;
  endfunction

  function automatic logic is_perm(logic [WAYS*RANK_W-1:0] r);
    logic ok;
    int   n;
    ok = 1'b1;
    for (int v = 0; v < WAYS; v++) begin
      n = 0;
      for (int i = 0; i < WAYS; i++) if (r[i*RANK_W +: RANK_W] == RANK_W'(v)) n++;
      if (n != 1) ok = 1'b0;
    end
    return ok;
  endfunction

  logic perm_ok;
  logic free_victim_empty;
  assign perm_ok           = is_perm(rank_o);
  assign free_victim_empty = !way_valid_o[victim_way_o];

  a_r2_rank_permutation: assert property (@(posedge clk) disable iff (rst)
    perm_ok);

  a_r4_fill_lands_mru: assert property (@(posedge clk) disable iff (rst)
    fill_vld_i |=> (rank_of(rank_o, $past(fill_way_i)) == '0 && way_valid_o[$past(fill_way_i)]));

  a_r5_fetch_mru_mem_next: assert property (@(posedge clk) disable iff (rst)
    (fe_hit_vld_i && ms_hit_vld_i && !fill_vld_i && fe_hit_way_i != ms_hit_way_i)
    |=> (rank_of(rank_o, $past(fe_hit_way_i)) == '0 &&
         rank_of(rank_o, $past(ms_hit_way_i)) == RANK_W'(1)));

  a_r3_fetch_hit_mru: assert property (@(posedge clk) disable iff (rst)
    (fe_hit_vld_i && !fill_vld_i) |=> rank_of(rank_o, $past(fe_hit_way_i)) == '0);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!fe_hit_vld_i && !ms_hit_vld_i && !fill_vld_i) |=> $stable(rank_o));

  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~way_valid_o & $past(way_valid_o)) == '0));

  a_r8_free_victim_empty: assert property (@(posedge clk) disable iff (rst)
    victim_free_o |-> free_victim_empty);
endmodule

bind lru_set_tracker lru_set_tracker_chk #(
  .WAYS   (WAYS),
  .WAY_W  (WAY_W),
  .RANK_W (RANK_W)
) chk_i (.*);

// File: tb/lru_set_tracker_tb.sv
`timescale 1ns/1ps
module lru_set_tracker_tb_top;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int RANK_W = 2;
  localparam int MAX_CYC = 20000;

  logic                   clk = 1'b0;
  logic                   rst;
  logic                   fe_vld, ms_vld, fill_vld;
  logic [WAY_W-1:0]       fe_way, ms_way, fill_way;
  logic [WAYS*RANK_W-1:0] rank_o;
  logic [WAYS-1:0]        way_valid_o;
  logic [WAY_W-1:0]       victim_way_o;
  logic                   victim_free_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_rank [WAYS];
  bit m_val  [WAYS];

  always #2.5 clk = ~clk;

  lru_set_tracker #(.WAYS(WAYS)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .fe_hit_vld_i  (fe_vld),
    .fe_hit_way_i  (fe_way),
    .ms_hit_vld_i  (ms_vld),
    .ms_hit_way_i  (ms_way),
    .fill_vld_i    (fill_vld),
    .fill_way_i    (fill_way),
    .rank_o        (rank_o),
    .way_valid_o   (way_valid_o),
    .victim_way_o  (victim_way_o),
    .victim_free_o (victim_free_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_touch(int w);
    int old;
    old = m_rank[w];
    for (int i = 0; i < WAYS; i++) begin
      if (i == w) m_rank[i] = 0;
      else if (m_rank[i] < old) m_rank[i] = m_rank[i] + 1;
    end
  endtask

  task automatic compare(string req);
    int ev;
    bit ef;
    int seen;
    for (int i = 0; i < WAYS; i++) begin
      chk(req, $sformatf("rank way%0d", i), int'(rank_o[i*RANK_W +: RANK_W]), m_rank[i]);
    end
    chk("R7", "valid bits", int'(way_valid_o),
        int'({m_val[3], m_val[2], m_val[1], m_val[0]}));
    seen = 0;
    for (int i = 0; i < WAYS; i++) seen |= (1 << rank_o[i*RANK_W +: RANK_W]);
    chk("R2", "rank set", seen, (1 << WAYS) - 1);
    ef = 1'b0;
    ev = 0;
    for (int i = WAYS - 1; i >= 0; i--) if (!m_val[i]) begin ev = i; ef = 1'b1; end
    if (!ef) for (int i = 0; i < WAYS; i++) if (m_rank[i] == WAYS - 1) ev = i;
    chk("R8", "victim way", int'(victim_way_o), ev);
    chk("R8", "victim free", int'(victim_free_o), int'(ef));
  endtask

  // A code of WAYS means the source is idle.
  task automatic step(int ms, int fe, int fl);
    string req;
    ms_vld   = (ms < WAYS);  ms_way   = WAY_W'(ms);
    fe_vld   = (fe < WAYS);  fe_way   = WAY_W'(fe);
    fill_vld = (fl < WAYS);  fill_way = WAY_W'(fl);
    if (ms < WAYS) model_touch(ms);
    if (fe < WAYS) model_touch(fe);
    if (fl < WAYS) begin model_touch(fl); m_val[fl] = 1'b1; end
    if (fl < WAYS)                          req = "R4";
    else if (ms < WAYS && fe < WAYS && ms != fe) req = "R5";
    else if (ms < WAYS && fe < WAYS)        req = "R6";
    else if (ms < WAYS || fe < WAYS)        req = "R3";
    else                                    req = "R7";
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    rst = 1'b1;
    ms_vld = 0; fe_vld = 0; fill_vld = 0;
    ms_way = '0; fe_way = '0; fill_way = '0;
    for (int i = 0; i < WAYS; i++) begin m_rank[i] = i; m_val[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");
    chk("R1", "free after reset", int'(victim_free_o), 1);
    // Hits on empty ways keep them empty (R7).
    step(2, 1, WAYS);
    step(WAYS, WAYS, WAYS);
    // Forward sweep from an empty set.
    for (int a = 0; a <= WAYS; a++)
      for (int b = 0; b <= WAYS; b++)
        for (int c = 0; c <= WAYS; c++)
          step(a, b, c);
    // Reverse sweep on a full set.
    for (int a = WAYS; a >= 0; a--)
      for (int b = WAYS; b >= 0; b--)
        for (int c = WAYS; c >= 0; c--)
          step(c, a, b);
    // Explicit R5 and R6 patterns.
    step(3, 0, WAYS);
    chk("R5", "fetch way at MRU", int'(rank_o[0 +: RANK_W]), 0);
    chk("R5", "mem way at MRU-1", int'(rank_o[3*RANK_W +: RANK_W]), 1);
    step(2, 2, WAYS);
    chk("R6", "shared way at MRU", int'(rank_o[2*RANK_W +: RANK_W]), 0);
    step(WAYS, WAYS, WAYS);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule